// File: doc/BRIEF.md
# Interrupt Domain Register Front End

This block is the software-visible face of a message-signalled interrupt domain. A 32-bit request/response port carries loads and stores. The block decodes the offset and keeps the per-source trigger mode and delivery target words. It also keeps the domain interrupt-enable flag and the software-generated message word. Writes to the bitmap, by-number and byte-swapped number registers become one-cycle set/clear request pulses toward the interrupt gateway. The gateway owns the pending, enable and input-level state and presents it back as flat vectors, so that reads return the live state.

Every request gets a response exactly one cycle later. Accesses that are not aligned 32-bit words, and offsets that hit no register, get an error response and change nothing. After every accepted write the block pulses a rescan strobe, so that the forwarding scanner re-examines the sources whose state may have moved.

Top module: `aic_rif`

## Requirements
- R1: An access is accepted only when `req_addr[1:0]` is 0 and `req_bytes` is 4. Any other access returns `rsp_err`=1 and has no effect.
- R2: Each cycle with `req_valid` high yields `rsp_valid` high in the next cycle. A cycle without a request yields no response.
- R3: Offset 0x0000 is the domain register. A write stores only bit 8 (interrupt enable, driven on `dom_ie`). A read returns 0x80000000 | 0x4 | (enable << 8).
- R4: Offset 4·k (1 ≤ k ≤ NUM_SRC) is the trigger-mode word of source k. A write with bit 10 set stores 0; otherwise it stores bits [2:0]. Reads return the stored value, which also appears on `src_mode[3k+:3]`.
- R5: Offset 0x3000 + 4·k (1 ≤ k ≤ NUM_SRC) is the target word of source k. A write keeps bits [31:18], [17:12] and [10:0] and clears bit 11. Reads return the stored word, which also appears on `src_target[32k+:32]`.
- R6: Bitmap word w sits at base + 4·w for w < ceil((NUM_SRC+1)/32). The bases are 0x1C00 set-pending, 0x1D00 clear-pending, 0x1E00 set-enable and 0x1F00 clear-enable. Bit i of word w addresses source 32·w+i: a 1 pulses that source's request and a 0 does nothing. Source 0 is never pulsed.
- R7: Bitmap reads return `gw_pending` from the set-pending array, `gw_level` from the clear-pending array, `gw_enabled` from the set-enable array, and 0 from the clear-enable array. Bit 0 of word 0 always reads 0.
- R8: Writes to the by-number registers pulse one request for the source whose number equals the write data: 0x1CDC and 0x2000 set pending, 0x1DDC clears pending, 0x1EDC sets enable and 0x1FDC clears enable. A number of 0 or above NUM_SRC pulses nothing. All by-number registers read 0.
- R9: Offset 0x2004 reverses the byte order of the write data and then acts as set-pending by number. It reads 0.
- R10: Offset 0x3000 is the message register. A write stores the data with bits [17:12] cleared, pulses `msi_gen_valid` for one cycle and presents the stored word on `msi_gen_data`. A read returns the stored word.
- R11: Offsets that hit no register, including array words and source numbers past the implemented range, return `rsp_err`=1 and read data 0. They pulse nothing and change no state.
- R12: `rescan` pulses for one cycle with the response of every accepted write, and never for reads or errors.
- R13: Request pulses, `msi_gen_valid` and `rescan` are high only in the response cycle of the write that caused them, and low in the next cycle unless another write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte offset within the domain |
| req_bytes | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Unsupported access |
| rsp_rdata | output | 32 | Load data |
| gw_pending | input | NUM_SRC+1 | Pending flags from the gateway |
| gw_enabled | input | NUM_SRC+1 | Enable flags from the gateway |
| gw_level | input | NUM_SRC+1 | Raw input levels from the gateway |
| pend_set | output | NUM_SRC+1 | Set-pending request pulses |
| pend_clr | output | NUM_SRC+1 | Clear-pending request pulses |
| en_set | output | NUM_SRC+1 | Set-enable request pulses |
| en_clr | output | NUM_SRC+1 | Clear-enable request pulses |
| src_mode | output | 3·(NUM_SRC+1) | Trigger mode per source |
| src_target | output | 32·(NUM_SRC+1) | Target word per source |
| dom_ie | output | 1 | Domain interrupt enable |
| msi_gen_valid | output | 1 | Software message request pulse |
| msi_gen_data | output | 32 | Stored software message word |
| rescan | output | 1 | Rescan strobe after an accepted write |

## Verification
Directed accesses first hit each register's edges. These are the first and last source of the configuration and target arrays, the word just past each bitmap array, the delegate bit, number 0 and a number past the range, and a byte-swapped number. Together they separate an off-by-one in the source mapping from a wrong field mask. A seeded random stream then mixes loads and stores over every region. It draws in wrong sizes and misaligned offsets, and changes the gateway vectors on every access, so that a read mux which routes the wrong vector, or a stale capture, disagrees with the model. After each access the bench checks an idle cycle, which tells a one-cycle strobe apart from a held one.

// File: rtl/aic_rif_pkg.sv
package aic_rif_pkg;

    // Offsets whose positions are decoded by software
    localparam logic [31:0] OFF_DOMCFG    = 32'h0000_0000;
    localparam logic [31:0] OFF_SETIP     = 32'h0000_1C00;
    localparam logic [31:0] OFF_SETIPNUM  = 32'h0000_1CDC;
    localparam logic [31:0] OFF_INCLR     = 32'h0000_1D00;
    localparam logic [31:0] OFF_CLRIPNUM  = 32'h0000_1DDC;
    localparam logic [31:0] OFF_SETIE     = 32'h0000_1E00;
    localparam logic [31:0] OFF_SETIENUM  = 32'h0000_1EDC;
    localparam logic [31:0] OFF_CLRIE     = 32'h0000_1F00;
    localparam logic [31:0] OFF_CLRIENUM  = 32'h0000_1FDC;
    localparam logic [31:0] OFF_NUM_LE    = 32'h0000_2000;
    localparam logic [31:0] OFF_NUM_BE    = 32'h0000_2004;
    localparam logic [31:0] OFF_GENMSI    = 32'h0000_3000;
    localparam logic [31:0] OFF_TGT_BASE  = 32'h0000_3000;

    localparam logic [31:0] DOM_FIXED     = 32'h8000_0000;
    localparam logic [31:0] DOM_MSI_MODE  = 32'h0000_0004;
    localparam int          DOM_IE_BIT    = 8;

    localparam int          SRC_DELEG_BIT = 10;
    localparam int          MODE_W        = 3;

    localparam logic [31:0] TGT_KEEP      = 32'hFFFF_F7FF;
    localparam logic [31:0] GUEST_FIELD   = 32'h0003_F000;

    localparam int          ACC_BYTES     = 4;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_DOMCFG,
        RG_SRCCFG,
        RG_SETIP,
        RG_SETIPNUM,
        RG_INCLR,
        RG_CLRIPNUM,
        RG_SETIE,
        RG_SETIENUM,
        RG_CLRIE,
        RG_CLRIENUM,
        RG_NUM_LE,
        RG_NUM_BE,
        RG_GENMSI,
        RG_TARGET
    } rif_region_e;

    typedef struct packed {
        rif_region_e region;
        logic [15:0] index;
    } rif_dec_t;

    function automatic logic [31:0] byte_swap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [MODE_W-1:0] srccfg_filter(input logic [31:0] v);
        return v[SRC_DELEG_BIT] ? '0 : v[MODE_W-1:0];
    endfunction

    function automatic logic [31:0] target_filter(input logic [31:0] v);
        return v & TGT_KEEP;
    endfunction

    function automatic logic [31:0] genmsi_filter(input logic [31:0] v);
        return v & ~GUEST_FIELD;
    endfunction

endpackage

// File: rtl/aic_rif_decode.sv
module aic_rif_decode
    import aic_rif_pkg::*;
#(
    parameter int NUM_SRC = 63
) (
    input  logic [31:0] addr,
    output rif_dec_t    dec
);
    localparam int          NW       = (NUM_SRC + 1 + 31) / 32;
    localparam logic [31:0] ARR_SPAN = 32'(4 * NW);
    localparam logic [31:0] CFG_END  = 32'(4 * NUM_SRC);

    function automatic logic in_array(input logic [31:0] a, input logic [31:0] base);
        return (a >= base) && (a < base + ARR_SPAN);
    endfunction

    function automatic logic [15:0] word_of(input logic [31:0] a, input logic [31:0] base);
        logic [31:0] rel;
        rel = (a - base) >> 2;
        return rel[15:0];
    endfunction

    always_comb begin
        dec.region = RG_NONE;
        dec.index  = '0;
        if (addr == OFF_DOMCFG) begin
            dec.region = RG_DOMCFG;
        end else if (addr >= 32'd4 && addr <= CFG_END) begin
            dec.region = RG_SRCCFG;
            dec.index  = word_of(addr, 32'd0);
        end else if (in_array(addr, OFF_SETIP)) begin
            dec.region = RG_SETIP;
            dec.index  = word_of(addr, OFF_SETIP);
        end else if (addr == OFF_SETIPNUM) begin
            dec.region = RG_SETIPNUM;
        end else if (in_array(addr, OFF_INCLR)) begin
            dec.region = RG_INCLR;
            dec.index  = word_of(addr, OFF_INCLR);
        end else if (addr == OFF_CLRIPNUM) begin
            dec.region = RG_CLRIPNUM;
        end else if (in_array(addr, OFF_SETIE)) begin
            dec.region = RG_SETIE;
            dec.index  = word_of(addr, OFF_SETIE);
        end else if (addr == OFF_SETIENUM) begin
            dec.region = RG_SETIENUM;
        end else if (in_array(addr, OFF_CLRIE)) begin
            dec.region = RG_CLRIE;
            dec.index  = word_of(addr, OFF_CLRIE);
        end else if (addr == OFF_CLRIENUM) begin
            dec.region = RG_CLRIENUM;
        end else if (addr == OFF_NUM_LE) begin
            dec.region = RG_NUM_LE;
        end else if (addr == OFF_NUM_BE) begin
            dec.region = RG_NUM_BE;
        end else if (addr == OFF_GENMSI) begin
            dec.region = RG_GENMSI;
        end else if (addr >= OFF_TGT_BASE + 32'd4 && addr <= OFF_TGT_BASE + CFG_END) begin
            dec.region = RG_TARGET;
            dec.index  = word_of(addr, OFF_TGT_BASE);
        end
    end

endmodule

// File: rtl/aic_rif_cfg.sv
module aic_rif_cfg
    import aic_rif_pkg::*;
#(
    parameter int NUM_SRC = 63
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_src,
    input  logic                           wr_tgt,
    input  logic [15:0]                    idx,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rd_src,
    output logic [31:0]                    rd_tgt,
    output logic [MODE_W*(NUM_SRC+1)-1:0]  mode_flat,
    output logic [32*(NUM_SRC+1)-1:0]      tgt_flat
);
    localparam int NS1 = NUM_SRC + 1;

    for (genvar k = 0; k < NS1; k++) begin : g_src
        if (k == 0) begin : g_absent
            assign mode_flat[MODE_W-1:0] = '0;
            assign tgt_flat[31:0]        = '0;
        end else begin : g_store
            logic [MODE_W-1:0] mode_q;
            logic [31:0]       tgt_q;
            logic              hit;

            assign hit = (idx == 16'(k));

            always_ff @(posedge clk) begin
                if (rst) begin
                    mode_q <= '0;
                    tgt_q  <= '0;
                end else begin
                    if (wr_src && hit) mode_q <= srccfg_filter(wdata);
                    if (wr_tgt && hit) tgt_q  <= target_filter(wdata);
                end
            end

            assign mode_flat[k*MODE_W +: MODE_W] = mode_q;
            assign tgt_flat[k*32 +: 32]          = tgt_q;
        end
    end

    always_comb begin
        rd_src = '0;
        rd_tgt = '0;
        if (int'(idx) < NS1) begin
            rd_src[MODE_W-1:0] = mode_flat[int'(idx)*MODE_W +: MODE_W];
            rd_tgt             = tgt_flat[int'(idx)*32 +: 32];
        end
    end

endmodule

// File: rtl/aic_rif_reqgen.sv
module aic_rif_reqgen
    import aic_rif_pkg::*;
#(
    parameter int NUM_SRC = 63
) (
    input  logic               wr_go,
    input  rif_dec_t           dec,
    input  logic [31:0]        wdata,
    output logic [NUM_SRC:0]   p_set,
    output logic [NUM_SRC:0]   p_clr,
    output logic [NUM_SRC:0]   e_set,
    output logic [NUM_SRC:0]   e_clr
);
    localparam int NS1 = NUM_SRC + 1;

    logic [31:0] num;
    logic        num_pset;

    assign num      = (dec.region == RG_NUM_BE) ? byte_swap32(wdata) : wdata;
    assign num_pset = (dec.region == RG_SETIPNUM) || (dec.region == RG_NUM_LE) ||
                      (dec.region == RG_NUM_BE);

    for (genvar k = 0; k < NS1; k++) begin : g_req
        if (k == 0) begin : g_absent
            assign p_set[0] = 1'b0;
            assign p_clr[0] = 1'b0;
            assign e_set[0] = 1'b0;
            assign e_clr[0] = 1'b0;
        end else begin : g_live
            localparam int WRD = k / 32;
            localparam int BIT = k % 32;
            logic bit_hit;
            logic num_hit;

            assign bit_hit = (dec.index == 16'(WRD)) && wdata[BIT];
            assign num_hit = (num == 32'(k));

            assign p_set[k] = wr_go && (((dec.region == RG_SETIP) && bit_hit) ||
                                        (num_pset && num_hit));
            assign p_clr[k] = wr_go && (((dec.region == RG_INCLR) && bit_hit) ||
                                        ((dec.region == RG_CLRIPNUM) && num_hit));
            assign e_set[k] = wr_go && (((dec.region == RG_SETIE) && bit_hit) ||
                                        ((dec.region == RG_SETIENUM) && num_hit));
            assign e_clr[k] = wr_go && (((dec.region == RG_CLRIE) && bit_hit) ||
                                        ((dec.region == RG_CLRIENUM) && num_hit));
        end
    end

endmodule

// File: rtl/aic_rif.sv
module aic_rif
    import aic_rif_pkg::*;
#(
    parameter int NUM_SRC = 63
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [31:0]                    req_addr,
    input  logic [2:0]                     req_bytes,
    input  logic [31:0]                    req_wdata,
    output logic                           rsp_valid,
    output logic                           rsp_err,
    output logic [31:0]                    rsp_rdata,
    input  logic [NUM_SRC:0]               gw_pending,
    input  logic [NUM_SRC:0]               gw_enabled,
    input  logic [NUM_SRC:0]               gw_level,
    output logic [NUM_SRC:0]               pend_set,
    output logic [NUM_SRC:0]               pend_clr,
    output logic [NUM_SRC:0]               en_set,
    output logic [NUM_SRC:0]               en_clr,
    output logic [3*(NUM_SRC+1)-1:0]       src_mode,
    output logic [32*(NUM_SRC+1)-1:0]      src_target,
    output logic                           dom_ie,
    output logic                           msi_gen_valid,
    output logic [31:0]                    msi_gen_data,
    output logic                           rescan
);
    localparam int NS1 = NUM_SRC + 1;
    localparam int NW  = (NS1 + 31) / 32;
    localparam int PAD = NW * 32;

    rif_dec_t    dec;
    logic        acc_ok;
    logic        wr_go;
    logic [31:0] rd_src;
    logic [31:0] rd_tgt;
    logic [31:0] rd_mux;
    logic [31:0] genmsi_q;
    logic        ie_q;

    logic [NUM_SRC:0] live_mask;
    logic [PAD-1:0]   pend_pad;
    logic [PAD-1:0]   lvl_pad;
    logic [PAD-1:0]   en_pad;

    logic [NUM_SRC:0] p_set_d;
    logic [NUM_SRC:0] p_clr_d;
    logic [NUM_SRC:0] e_set_d;
    logic [NUM_SRC:0] e_clr_d;

    aic_rif_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .addr (req_addr),
        .dec  (dec)
    );

    assign acc_ok = req_valid && (req_addr[1:0] == 2'b00) &&
                    (req_bytes == 3'(ACC_BYTES)) && (dec.region != RG_NONE);
    assign wr_go  = acc_ok && req_write;

    aic_rif_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_src    (wr_go && (dec.region == RG_SRCCFG)),
        .wr_tgt    (wr_go && (dec.region == RG_TARGET)),
        .idx       (dec.index),
        .wdata     (req_wdata),
        .rd_src    (rd_src),
        .rd_tgt    (rd_tgt),
        .mode_flat (src_mode),
        .tgt_flat  (src_target)
    );

    aic_rif_reqgen #(.NUM_SRC(NUM_SRC)) u_reqgen (
        .wr_go (wr_go),
        .dec   (dec),
        .wdata (req_wdata),
        .p_set (p_set_d),
        .p_clr (p_clr_d),
        .e_set (e_set_d),
        .e_clr (e_clr_d)
    );

    assign live_mask = {{NUM_SRC{1'b1}}, 1'b0};
    assign pend_pad  = PAD'(gw_pending & live_mask);
    assign lvl_pad   = PAD'(gw_level & live_mask);
    assign en_pad    = PAD'(gw_enabled & live_mask);

    always_comb begin
        rd_mux = '0;
        unique case (dec.region)
            RG_DOMCFG: rd_mux = DOM_FIXED | DOM_MSI_MODE | (32'(ie_q) << DOM_IE_BIT);
            RG_SRCCFG: rd_mux = rd_src;
            RG_SETIP:  if (int'(dec.index) < NW) rd_mux = pend_pad[int'(dec.index)*32 +: 32];
            RG_INCLR:  if (int'(dec.index) < NW) rd_mux = lvl_pad[int'(dec.index)*32 +: 32];
            RG_SETIE:  if (int'(dec.index) < NW) rd_mux = en_pad[int'(dec.index)*32 +: 32];
            RG_GENMSI: rd_mux = genmsi_q;
            RG_TARGET: rd_mux = rd_tgt;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_err       <= 1'b0;
            rsp_rdata     <= '0;
            ie_q          <= 1'b0;
            genmsi_q      <= '0;
            msi_gen_valid <= 1'b0;
            rescan        <= 1'b0;
            pend_set      <= '0;
            pend_clr      <= '0;
            en_set        <= '0;
            en_clr        <= '0;
        end else begin
            rsp_valid     <= req_valid;
            rsp_err       <= req_valid && !acc_ok;
            rsp_rdata     <= (acc_ok && !req_write) ? rd_mux : '0;
            msi_gen_valid <= wr_go && (dec.region == RG_GENMSI);
            rescan        <= wr_go;
            pend_set      <= p_set_d;
            pend_clr      <= p_clr_d;
            en_set        <= e_set_d;
            en_clr        <= e_clr_d;
            if (wr_go && dec.region == RG_DOMCFG) ie_q     <= req_wdata[DOM_IE_BIT];
            if (wr_go && dec.region == RG_GENMSI) genmsi_q <= genmsi_filter(req_wdata);
        end
    end

    assign dom_ie       = ie_q;
    assign msi_gen_data = genmsi_q;

endmodule

// File: rtl/aic_rif_chk.sv
module aic_rif_chk #(
    parameter int NUM_SRC = 63
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_write,
    input logic [31:0]        req_addr,
    input logic [2:0]         req_bytes,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic [NUM_SRC:0]   pend_set,
    input logic [NUM_SRC:0]   pend_clr,
    input logic [NUM_SRC:0]   en_set,
    input logic [NUM_SRC:0]   en_clr,
    input logic               msi_gen_valid,
    input logic               rescan
);
    logic any_pulse;
    assign any_pulse = (|pend_set) || (|pend_clr) || (|en_set) || (|en_clr) || msi_gen_valid;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);  // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);  // R2
    AST_BAD_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err);  // R1
    AST_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bytes != 3'd4) |=> rsp_err);  // R1
    AST_ERR_INERT: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (!rescan && !any_pulse));  // R11
    AST_RESCAN_WR: assert property (@(posedge clk) disable iff (rst)
        rescan |-> (rsp_valid && !rsp_err && $past(req_write)));  // R12
    AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(pend_set[0] || pend_clr[0] || en_set[0] || en_clr[0]));  // R6
    AST_PEND_EXCL: assert property (@(posedge clk) disable iff (rst)
        ((pend_set & pend_clr) == '0) && ((en_set & en_clr) == '0));  // R6
    AST_PULSE_WITH_WR: assert property (@(posedge clk) disable iff (rst)
        any_pulse |-> rescan);  // R13

endmodule

bind aic_rif aic_rif_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/aic_rif_test.sv
module aic_rif_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 63;
    localparam int NW = (N + 1 + 31) / 32;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 req_valid;
    logic                 req_write;
    logic [31:0]          req_addr;
    logic [2:0]           req_bytes;
    logic [31:0]          req_wdata;
    logic                 rsp_valid;
    logic                 rsp_err;
    logic [31:0]          rsp_rdata;
    logic [N:0]           gw_pending;
    logic [N:0]           gw_enabled;
    logic [N:0]           gw_level;
    logic [N:0]           pend_set;
    logic [N:0]           pend_clr;
    logic [N:0]           en_set;
    logic [N:0]           en_clr;
    logic [3*(N+1)-1:0]   src_mode;
    logic [32*(N+1)-1:0]  src_target;
    logic                 dom_ie;
    logic                 msi_gen_valid;
    logic [31:0]          msi_gen_data;
    logic                 rescan;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [2:0]  m_mode [N+1];
    logic [31:0] m_tgt  [N+1];
    logic        m_ie;
    logic [31:0] m_gen;

    always #(CLK_PERIOD/2) clk = ~clk;

    aic_rif #(.NUM_SRC(N)) uut (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // region codes: 0 none 1 dom 2 src 3 setip 4 setipnum 5 inclr 6 clripnum
    // 7 setie 8 setienum 9 clrie 10 clrienum 11 le 12 be 13 gen 14 tgt
    function automatic int exp_region(input logic [31:0] a, output int idx);
        idx = 0;
        if (a == 32'h0) return 1;
        if (a >= 32'd4 && a <= 32'(4*N)) begin idx = int'(a >> 2); return 2; end
        if (a >= 32'h1C00 && a < 32'h1C00 + 32'(4*NW)) begin idx = int'((a - 32'h1C00) >> 2); return 3; end
        if (a == 32'h1CDC) return 4;
        if (a >= 32'h1D00 && a < 32'h1D00 + 32'(4*NW)) begin idx = int'((a - 32'h1D00) >> 2); return 5; end
        if (a == 32'h1DDC) return 6;
        if (a >= 32'h1E00 && a < 32'h1E00 + 32'(4*NW)) begin idx = int'((a - 32'h1E00) >> 2); return 7; end
        if (a == 32'h1EDC) return 8;
        if (a >= 32'h1F00 && a < 32'h1F00 + 32'(4*NW)) begin idx = int'((a - 32'h1F00) >> 2); return 9; end
        if (a == 32'h1FDC) return 10;
        if (a == 32'h2000) return 11;
        if (a == 32'h2004) return 12;
        if (a == 32'h3000) return 13;
        if (a >= 32'h3004 && a <= 32'h3000 + 32'(4*N)) begin idx = int'((a - 32'h3000) >> 2); return 14; end
        return 0;
    endfunction

    function automatic logic [31:0] word_of(input logic [N:0] v, input int w);
        logic [NW*32-1:0] pad;
        pad = '0;
        pad[N:0] = v;
        pad[0] = 1'b0;
        return pad[w*32 +: 32];
    endfunction

    function automatic logic [31:0] pick_addr(input int rg, input int k, input int w);
        case (rg)
            1:  return 32'h0;
            2:  return 32'(4*k);
            3:  return 32'h1C00 + 32'(4*w);
            4:  return 32'h1CDC;
            5:  return 32'h1D00 + 32'(4*w);
            6:  return 32'h1DDC;
            7:  return 32'h1E00 + 32'(4*w);
            8:  return 32'h1EDC;
            9:  return 32'h1F00 + 32'(4*w);
            10: return 32'h1FDC;
            11: return 32'h2000;
            12: return 32'h2004;
            13: return 32'h3000;
            14: return 32'h3000 + 32'(4*k);
            default: return 32'h2100 + 32'(4*w);
        endcase
    endfunction

    task automatic access(input logic wr, input logic [31:0] a, input logic [2:0] nb,
                          input logic [31:0] wd, input string tag);
        int idx, rg;
        logic e_err, e_gen, b, nh;
        logic [31:0] e_rd, num;
        logic [N:0] e_ps, e_pc, e_es, e_ec;
        rg = exp_region(a, idx);
        e_err = (a[1:0] != 2'b00) || (nb != 3'd4) || (rg == 0);
        e_rd = '0; e_ps = '0; e_pc = '0; e_es = '0; e_ec = '0; e_gen = 1'b0;
        if (!e_err && !wr) begin
            case (rg)
                1:  e_rd = 32'h8000_0004 | (32'(m_ie) << 8);
                2:  e_rd = {29'b0, m_mode[idx]};
                3:  e_rd = word_of(gw_pending, idx);
                5:  e_rd = word_of(gw_level, idx);
                7:  e_rd = word_of(gw_enabled, idx);
                13: e_rd = m_gen;
                14: e_rd = m_tgt[idx];
                default: e_rd = '0;
            endcase
        end
        if (!e_err && wr) begin
            num = (rg == 12) ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} : wd;
            for (int s = 1; s <= N; s++) begin
                b  = ((s / 32) == idx) && wd[s % 32];
                nh = (num == 32'(s));
                e_ps[s] = (rg == 3 && b) || ((rg == 4 || rg == 11 || rg == 12) && nh);
                e_pc[s] = (rg == 5 && b) || (rg == 6 && nh);
                e_es[s] = (rg == 7 && b) || (rg == 8 && nh);
                e_ec[s] = (rg == 9 && b) || (rg == 10 && nh);
            end
            e_gen = (rg == 13);
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_bytes = nb; req_wdata = wd;
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
        check(rsp_err == e_err, e_err ? "R1/R11" : tag, "rsp_err", 64'(rsp_err), 64'(e_err));
        check(rsp_rdata == e_rd, tag, "rdata", 64'(rsp_rdata), 64'(e_rd));
        check(pend_set == e_ps, tag, "pend_set", 64'(pend_set), 64'(e_ps));
        check(pend_clr == e_pc, tag, "pend_clr", 64'(pend_clr), 64'(e_pc));
        check(en_set == e_es, tag, "en_set", 64'(en_set), 64'(e_es));
        check(en_clr == e_ec, tag, "en_clr", 64'(en_clr), 64'(e_ec));
        check(msi_gen_valid == e_gen, "R10", "msi_gen_valid", 64'(msi_gen_valid), 64'(e_gen));
        check(rescan == (wr && !e_err), "R12", "rescan", 64'(rescan), 64'(wr && !e_err));
        req_valid = 1'b0;
        if (wr && !e_err) begin
            case (rg)
                1:  m_ie = wd[8];
                2:  m_mode[idx] = wd[10] ? 3'b000 : wd[2:0];
                13: m_gen = wd & ~32'h0003_F000;
                14: m_tgt[idx] = wd & 32'hFFFF_F7FF;
                default: ;
            endcase
        end
        @(negedge clk);
        check(!rsp_valid && !rescan && !msi_gen_valid && pend_set == '0 && pend_clr == '0 &&
              en_set == '0 && en_clr == '0, "R13", "idle strobes",
              {rsp_valid, rescan, msi_gen_valid, |pend_set, |pend_clr, |en_set, |en_clr}, 64'd0);
        check(dom_ie == m_ie, "R3", "dom_ie", 64'(dom_ie), 64'(m_ie));
        check(msi_gen_data == m_gen, "R10", "msi_gen_data", 64'(msi_gen_data), 64'(m_gen));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s <= N; s++) begin m_mode[s] = '0; m_tgt[s] = '0; end
        m_ie = 1'b0; m_gen = '0;
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_bytes = 3'd4; req_wdata = '0;
        gw_pending = '0; gw_enabled = '0; gw_level = '0;
        repeat (3) @(negedge clk);
        check(!rsp_valid && !rescan && !dom_ie && !msi_gen_valid && src_mode == '0,
              "R2", "reset state", {rsp_valid, rescan, dom_ie, msi_gen_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        gw_pending = {$urandom, $urandom} | 64'h1;
        gw_enabled = {$urandom, $urandom};
        gw_level   = {$urandom, $urandom} | 64'h1;

        // R3 domain register
        access(1'b0, 32'h0, 3'd4, 32'h0, "R3");
        access(1'b1, 32'h0, 3'd4, 32'hFFFF_FFFF, "R3");
        access(1'b0, 32'h0, 3'd4, 32'h0, "R3");
        // R4 source configuration edges
        access(1'b1, 32'h4, 3'd4, 32'h0000_0406, "R4");
        access(1'b0, 32'h4, 3'd4, 32'h0, "R4");
        access(1'b1, 32'hFC, 3'd4, 32'hFFFF_FBFD, "R4");
        access(1'b0, 32'hFC, 3'd4, 32'h0, "R4");
        check(src_mode[63*3 +: 3] == 3'd5, "R4", "src_mode[63]", 64'(src_mode[63*3 +: 3]), 64'd5);
        access(1'b1, 32'h100, 3'd4, 32'h7, "R11");
        // R5 target words
        access(1'b1, 32'h3004, 3'd4, 32'hFFFF_FFFF, "R5");
        access(1'b0, 32'h3004, 3'd4, 32'h0, "R5");
        check(src_target[32 +: 32] == 32'hFFFF_F7FF, "R5", "src_target[1]",
              64'(src_target[32 +: 32]), 64'hFFFF_F7FF);
        access(1'b1, 32'h30FC, 3'd4, 32'h1234_5ABC, "R5");
        access(1'b1, 32'h3100, 3'd4, 32'h1, "R11");
        // R10 message register
        access(1'b1, 32'h3000, 3'd4, 32'hFFFF_FFFF, "R10");
        access(1'b0, 32'h3000, 3'd4, 32'h0, "R10");
        // R6 / R7 bitmaps
        access(1'b1, 32'h1C00, 3'd4, 32'hFFFF_FFFF, "R6");
        access(1'b1, 32'h1E04, 3'd4, 32'h8000_0001, "R6");
        access(1'b1, 32'h1D04, 3'd4, 32'h0, "R6");
        access(1'b1, 32'h1C08, 3'd4, 32'hFFFF_FFFF, "R11");
        access(1'b0, 32'h1C00, 3'd4, 32'h0, "R7");
        access(1'b0, 32'h1D00, 3'd4, 32'h0, "R7");
        access(1'b0, 32'h1E04, 3'd4, 32'h0, "R7");
        access(1'b0, 32'h1F00, 3'd4, 32'h0, "R7");
        // R8 / R9 by number
        access(1'b1, 32'h1CDC, 3'd4, 32'd5, "R8");
        access(1'b1, 32'h1DDC, 3'd4, 32'd63, "R8");
        access(1'b1, 32'h1FDC, 3'd4, 32'd0, "R8");
        access(1'b1, 32'h1EDC, 3'd4, 32'd64, "R8");
        access(1'b1, 32'h2000, 3'd4, 32'd40, "R8");
        access(1'b0, 32'h1CDC, 3'd4, 32'h0, "R8");
        access(1'b1, 32'h2004, 3'd4, 32'h0500_0000, "R9");
        access(1'b1, 32'h2004, 3'd4, 32'h0000_0005, "R9");
        access(1'b0, 32'h2004, 3'd4, 32'h0, "R9");
        // R1 / R11 rejects
        access(1'b1, 32'h0000_0006, 3'd4, 32'hFFFF_FFFF, "R1");
        access(1'b1, 32'h0000_0000, 3'd2, 32'h0, "R1");
        access(1'b0, 32'h0000_3001, 3'd4, 32'h0, "R1");
        access(1'b1, 32'h0000_2008, 3'd4, 32'h0, "R11");
        access(1'b0, 32'h0001_0000, 3'd4, 32'h0, "R11");

        // constrained random mix
        for (int t = 0; t < 600; t++) begin
            int rg, k, w;
            logic wr;
            logic [31:0] a, wd;
            logic [2:0] nb;
            gw_pending = {$urandom, $urandom};
            gw_enabled = {$urandom, $urandom};
            gw_level   = {$urandom, $urandom};
            rg = int'($urandom_range(0, 14));
            k  = int'($urandom_range(1, N + 1));
            w  = int'($urandom_range(0, NW));
            wr = 1'($urandom_range(0, 1));
            a  = pick_addr(rg, k, w);
            if ($urandom_range(0, 15) == 0) a = a + 32'd2;
            nb = ($urandom_range(0, 9) == 0) ? 3'd2 : 3'd4;
            wd = $urandom;
            if (rg == 4 || rg == 6 || rg == 8 || rg == 10 || rg == 11)
                wd = 32'($urandom_range(0, N + 4));
            if (rg == 12) wd = {8'($urandom_range(0, N + 4)), 24'h0};
            access(wr, a, nb, wd, "RAND");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule